// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block is a hardware sequencer that moves a processor clock domain safely across a PLL retune. While the PLL is being reprogrammed, the domain runs from an alternate clock source. The block performs the register writes and status polling around that window. A pre-change request carries the old rate, the new rate and the alternate-source rate, all in Hz. The sequencer finds the divider words for the new rate in an external configuration table, in which each row holds a rate in kHz. When the alternate source could overshoot, it first slows the domain with a safe divider. It then moves the clock mux to the alternate source, loads the new divider words and raises a "PLL may retune" level.

A later post-change request moves the mux back to the PLL and returns the low divider field to divide-by-1. Every wait polls a status input and gives up after a fixed number of cycles. On a timeout it flags an error and carries on. Moves to or from the 26 MHz oscillator rate need no action: both phases complete without touching the clock registers.

Top module: `cpuclk_rate_seq`

## Requirements
- R1: After reset, busy, done, pll_go, mux_alt, div0_we and div1_we are low, and div0_q and div1_q are zero.
- R2: The table is read row by row from index 0. A row matches when its kHz value times 1000 equals the new rate. A zero row, or the last row (TBL_DEPTH-1) not matching, sets err_lookup. In that case no divider is written, mux_alt does not change and pll_go stays low.
- R3: The safe divider is written only when alt_rate > old_rate or old_rate > new_rate. Otherwise the pre-change phase makes exactly one div0 write.
- R4: The safe value is ceil(alt_rate / min(old_rate, new_rate)) - 1, and it is written into div0 bits [2:0]. All other bits are kept. warn_div is set when the value is 8 or more, and the field then holds its low 3 bits.
- R5: The pre-change order is: safe write and settle (div0_busy low), then mux_alt high and a wait for mux_stat == 2, then div0 = table word OR'd with the safe value, then div1. At the moment mux_alt rises, div0_q holds the safe word.
- R6: Post-change drives mux_alt low and waits for mux_stat == 1. It then clears div0 bits [2:0] and keeps the other bits.
- R7: Each wait ends after TMO_CYC cycles without a match. err_timeout is then set and the sequence goes on to its next step.
- R8: If old_rate or new_rate equals OSC_HZ (26 MHz), both phases complete with done but make no divider write and no mux change.
- R9: With cfg_dbg_hold, the safe write also forces div0 bits [18:16] to 7. Post-change then restores bits [18:16] from the matched table word.
- R10: With cfg_has_div1, div1 is written once per pre-change. It takes the table word, or, when mon_src_alt is high, the current bits [6:4] and [2:0] with all other bits cleared.
- R11: busy is high from the accept edge until done. done is a one-cycle pulse. A post request with no successful pre-change before it is ignored, and so is a pre request while the sequencer is armed.
- R12: pll_go goes high after a successful pre-change and stays high until a post request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_req | input | 1 | Start the pre-change phase |
| post_req | input | 1 | Start the post-change phase |
| old_rate | input | 32 | Current PLL rate, Hz |
| new_rate | input | 32 | Target PLL rate, Hz |
| alt_rate | input | 32 | Alternate-source rate, Hz |
| cfg_dbg_hold | input | 1 | Also hold the debug divider field at a safe value |
| cfg_has_div1 | input | 1 | Second divider word present |
| mon_src_alt | input | 1 | Monitor clock not sourced from the PLL |
| tbl_idx | output | IDX_W | Table row being read |
| tbl_khz | input | 32 | Row rate in kHz, zero terminates |
| tbl_div0 | input | 32 | Row first divider word |
| tbl_div1 | input | 32 | Row second divider word |
| mux_alt | output | 1 | Mux select, 1 = alternate source |
| mux_stat | input | 3 | Mux status: 1 main, 2 alternate |
| div0_q | output | 32 | First divider word |
| div0_we | output | 1 | div0_q was just written |
| div0_busy | input | 1 | First divider settling |
| div1_q | output | 32 | Second divider word |
| div1_we | output | 1 | div1_q was just written |
| div1_busy | input | 1 | Second divider settling |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Phase complete pulse |
| pll_go | output | 1 | PLL may be retuned |
| err_lookup | output | 1 | No table row for new rate |
| err_timeout | output | 1 | A wait expired |
| warn_div | output | 1 | Safe divider out of range |

## Verification
The pre-change phase is driven with five rate patterns, and each one separates different behaviour:
- A rising rate with a slower alternate source shows that no safe write happens.
- A falling rate takes the safe path through the rate-drop condition.
- A rising rate with a faster alternate source takes the safe path through the alternate-speed condition, and gives a different quotient.
- A very fast alternate source gives a quotient over range and raises the warning.
- An oscillator-rate target skips both phases.

A new rate that is not in the table and a mux status stuck away from 2 exercise the two error paths. Running the debug-hold and monitor-keep options together with a falling rate tells the masked safe word and the kept second divider apart from their table values. Out-of-turn requests check the one-at-a-time rule.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;
  localparam int RATE_W  = 32;
  localparam int WORD_W  = 32;
  localparam int FLD_W   = 3;
  localparam int DBG_POS = 16;
  localparam int MUL_W   = RATE_W + 10;

  typedef logic [RATE_W-1:0] rate_t;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t LOW_FLD   = {{(WORD_W-FLD_W){1'b0}}, {FLD_W{1'b1}}};
  localparam word_t DBG_FLD   = LOW_FLD << DBG_POS;
  localparam word_t KEEP1_FLD = LOW_FLD | (LOW_FLD << 4);

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_CALC, S_SAFE_WR, S_SAFE_WT, S_MUX_WR, S_MUX_WT,
    S_D0_WR, S_D0_WT, S_D1_WR, S_D1_WT, S_PM_WR, S_PM_WT, S_PD_WR,
    S_PD_WT, S_FIN
  } seq_state_e;

  function automatic word_t field_merge(word_t cur, word_t val, word_t mask);
    return (cur & ~mask) | (val & mask);
  endfunction

  function automatic logic safe_needed(rate_t old_r, rate_t new_r, rate_t alt_r);
    return (alt_r > old_r) || (old_r > new_r);
  endfunction

  function automatic rate_t rate_min(rate_t a, rate_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic khz_equals(rate_t khz, rate_t hz);
    logic [MUL_W-1:0] scaled;
    scaled = {10'b0, khz} * MUL_W'(1000);
    return scaled == {10'b0, hz};
  endfunction
endpackage

// File: rtl/rate_ceil_div.sv
module rate_ceil_div #(
  parameter int RW = 32,
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] num,
  input  logic [RW-1:0] den,
  output logic          run,
  output logic          fin,
  output logic [QW-1:0] quo
);
  localparam int AW = RW + QW;
  localparam logic [QW-1:0] QCAP = '1;

  logic [AW-1:0] acc;
  logic [QW-1:0] q;
  logic [AW-1:0] num_x, den_x;
  logic reached, capped;

  assign num_x   = {{QW{1'b0}}, num};
  assign den_x   = {{QW{1'b0}}, den};
  assign reached = acc >= num_x;
  assign capped  = q == QCAP;
  assign fin     = run && (reached || capped);
  assign quo     = (q == '0) ? '0 : q - QW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      acc <= '0;
      q   <= '0;
    end else if (start) begin
      run <= 1'b1;
      acc <= '0;
      q   <= '0;
    end else if (run) begin
      if (reached || capped) begin
        run <= 1'b0;
      end else begin
        acc <= acc + den_x;
        q   <= q + QW'(1);
      end
    end
  end

  // R4
  div_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !run);
endmodule

// File: rtl/stat_waiter.sv
module stat_waiter #(
  parameter int TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cond,
  output logic fin,
  output logic expired
);
  localparam int CW = $clog2(TMO + 1);
  logic [CW-1:0] cnt;
  logic last;

  assign last    = cnt == CW'(TMO - 1);
  assign fin     = active && (cond || last);
  assign expired = active && !cond && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!active || fin) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end

  // R7
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < CW'(TMO)));
endmodule

// File: rtl/cpuclk_rate_seq.sv
module cpuclk_rate_seq
  import cpuclk_seq_pkg::*;
#(
  parameter int          TBL_DEPTH = 8,
  parameter int          TMO_CYC   = 64,
  parameter int          QUOT_W    = 4,
  parameter int unsigned OSC_HZ    = 26_000_000,
  localparam int         IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_req,
  input  logic              post_req,
  input  logic [RATE_W-1:0] old_rate,
  input  logic [RATE_W-1:0] new_rate,
  input  logic [RATE_W-1:0] alt_rate,
  input  logic              cfg_dbg_hold,
  input  logic              cfg_has_div1,
  input  logic              mon_src_alt,
  output logic [IDX_W-1:0]  tbl_idx,
  input  logic [RATE_W-1:0] tbl_khz,
  input  logic [WORD_W-1:0] tbl_div0,
  input  logic [WORD_W-1:0] tbl_div1,
  output logic              mux_alt,
  input  logic [2:0]        mux_stat,
  output logic [WORD_W-1:0] div0_q,
  output logic              div0_we,
  input  logic              div0_busy,
  output logic [WORD_W-1:0] div1_q,
  output logic              div1_we,
  input  logic              div1_busy,
  output logic              busy,
  output logic              done,
  output logic              pll_go,
  output logic              err_lookup,
  output logic              err_timeout,
  output logic              warn_div
);
  localparam int DIV_LIMIT = 1 << FLD_W;

  seq_state_e state;
  rate_t old_r, new_r, alt_r;
  logic [IDX_W-1:0] idx;
  word_t ent0, ent1;
  logic need_r, post_ph, skip_r, armed;
  logic [QUOT_W-1:0] altdiv_r;

  // named events
  logic accept_pre, accept_post, osc_hit;
  logic tbl_end, tbl_hit, tbl_last, safe_cond;
  logic div_start, div_run, div_fin;
  logic [QUOT_W-1:0] div_quo;
  logic wait_active, wait_cond, wait_fin, wait_tmo;
  word_t alt_field, hold_mask, safe_val, post_val;

  assign busy        = state != S_IDLE;
  assign tbl_idx     = idx;
  assign accept_pre  = (state == S_IDLE) && pre_req && !armed;
  assign accept_post = (state == S_IDLE) && post_req && armed;
  assign osc_hit     = (old_rate == RATE_W'(OSC_HZ)) || (new_rate == RATE_W'(OSC_HZ));
  assign tbl_end     = tbl_khz == '0;
  assign tbl_hit     = !tbl_end && khz_equals(tbl_khz, new_r);
  assign tbl_last    = idx == IDX_W'(TBL_DEPTH - 1);
  assign safe_cond   = safe_needed(old_r, new_r, alt_r);
  assign div_start   = (state == S_LOOK) && tbl_hit && safe_cond;

  assign alt_field = {{(WORD_W-FLD_W){1'b0}}, altdiv_r[FLD_W-1:0]};
  assign hold_mask = LOW_FLD | (cfg_dbg_hold ? DBG_FLD : '0);
  assign safe_val  = alt_field | (cfg_dbg_hold ? DBG_FLD : '0);
  assign post_val  = cfg_dbg_hold ? (ent0 & DBG_FLD) : '0;

  rate_ceil_div #(.RW(RATE_W), .QW(QUOT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(alt_r), .den(rate_min(old_r, new_r)),
    .run(div_run), .fin(div_fin), .quo(div_quo)
  );

  always_comb begin
    wait_active = 1'b1;
    wait_cond   = 1'b0;
    unique case (state)
      S_SAFE_WT, S_D0_WT, S_PD_WT: wait_cond = !div0_busy;
      S_D1_WT:                     wait_cond = !div1_busy;
      S_MUX_WT:                    wait_cond = mux_stat == 3'd2;
      S_PM_WT:                     wait_cond = mux_stat == 3'd1;
      default:                     wait_active = 1'b0;
    endcase
  end

  stat_waiter #(.TMO(TMO_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(wait_active), .cond(wait_cond),
    .fin(wait_fin), .expired(wait_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      old_r <= '0; new_r <= '0; alt_r <= '0;
      idx <= '0; ent0 <= '0; ent1 <= '0;
      need_r <= 1'b0; post_ph <= 1'b0; skip_r <= 1'b0; armed <= 1'b0;
      altdiv_r <= '0;
      mux_alt <= 1'b0; div0_q <= '0; div1_q <= '0;
      div0_we <= 1'b0; div1_we <= 1'b0;
      done <= 1'b0; pll_go <= 1'b0;
      err_lookup <= 1'b0; err_timeout <= 1'b0; warn_div <= 1'b0;
    end else begin
      done    <= 1'b0;
      div0_we <= 1'b0;
      div1_we <= 1'b0;
      if (wait_tmo) err_timeout <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (accept_pre) begin
            old_r <= old_rate; new_r <= new_rate; alt_r <= alt_rate;
            err_lookup <= 1'b0; err_timeout <= 1'b0; warn_div <= 1'b0;
            post_ph <= 1'b0; idx <= '0; need_r <= 1'b0; altdiv_r <= '0;
            skip_r <= osc_hit;
            state <= osc_hit ? S_FIN : S_LOOK;
          end else if (accept_post) begin
            armed <= 1'b0; pll_go <= 1'b0; post_ph <= 1'b1;
            err_timeout <= 1'b0;
            state <= skip_r ? S_FIN : S_PM_WR;
          end
        end
        S_LOOK: begin
          if (tbl_end) begin
            err_lookup <= 1'b1; state <= S_FIN;
          end else if (tbl_hit) begin
            ent0 <= tbl_div0; ent1 <= tbl_div1; need_r <= safe_cond;
            state <= safe_cond ? S_CALC : S_MUX_WR;
          end else if (tbl_last) begin
            err_lookup <= 1'b1; state <= S_FIN;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_CALC: if (div_fin) begin
          altdiv_r <= div_quo;
          warn_div <= div_quo >= QUOT_W'(DIV_LIMIT);
          state    <= S_SAFE_WR;
        end
        S_SAFE_WR: begin
          div0_q <= field_merge(div0_q, safe_val, hold_mask);
          div0_we <= 1'b1; state <= S_SAFE_WT;
        end
        S_SAFE_WT: if (wait_fin) state <= S_MUX_WR;
        S_MUX_WR: begin mux_alt <= 1'b1; state <= S_MUX_WT; end
        S_MUX_WT: if (wait_fin) state <= S_D0_WR;
        S_D0_WR: begin
          div0_q <= ent0 | (need_r ? alt_field : '0);
          div0_we <= 1'b1; state <= S_D0_WT;
        end
        S_D0_WT: if (wait_fin) state <= cfg_has_div1 ? S_D1_WR : S_FIN;
        S_D1_WR: begin
          div1_q <= mon_src_alt ? (div1_q & KEEP1_FLD) : ent1;
          div1_we <= 1'b1; state <= S_D1_WT;
        end
        S_D1_WT: if (wait_fin) state <= S_FIN;
        S_PM_WR: begin mux_alt <= 1'b0; state <= S_PM_WT; end
        S_PM_WT: if (wait_fin) state <= S_PD_WR;
        S_PD_WR: begin
          div0_q <= field_merge(div0_q, post_val, hold_mask);
          div0_we <= 1'b1; state <= S_PD_WT;
        end
        S_PD_WT: if (wait_fin) state <= S_FIN;
        S_FIN: begin
          done <= 1'b1;
          if (!post_ph && !err_lookup) begin
            pll_go <= 1'b1; armed <= 1'b1;
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  mux_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pre_req && !post_req) |=> $stable(mux_alt));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  lookup_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_lookup |-> (!div0_we && !div1_we));
  // R12
  pll_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_go |-> !busy);
endmodule

// File: tb/test_cpuclk_rate_seq.sv
module test_cpuclk_rate_seq;
  localparam logic [31:0] OSC = 32'd26_000_000;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pre_req = 0, post_req = 0;
  logic [31:0] old_rate = 0, new_rate = 0, alt_rate = 0;
  logic cfg_dbg_hold = 0, cfg_has_div1 = 0, mon_src_alt = 0;
  logic [IW-1:0] tbl_idx;
  logic [31:0] tbl_khz, tbl_div0, tbl_div1;
  logic mux_alt; logic [2:0] mux_stat;
  logic [31:0] div0_q, div1_q;
  logic div0_we, div1_we, div0_busy, div1_busy;
  logic busy, done, pll_go, err_lookup, err_timeout, warn_div;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cpuclk_rate_seq #(.TBL_DEPTH(8), .TMO_CYC(16)) i_cpuclk_rate_seq (
    .clk(clk), .rst_n(rst_n), .pre_req(pre_req), .post_req(post_req),
    .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
    .cfg_dbg_hold(cfg_dbg_hold), .cfg_has_div1(cfg_has_div1), .mon_src_alt(mon_src_alt),
    .tbl_idx(tbl_idx), .tbl_khz(tbl_khz), .tbl_div0(tbl_div0), .tbl_div1(tbl_div1),
    .mux_alt(mux_alt), .mux_stat(mux_stat),
    .div0_q(div0_q), .div0_we(div0_we), .div0_busy(div0_busy),
    .div1_q(div1_q), .div1_we(div1_we), .div1_busy(div1_busy),
    .busy(busy), .done(done), .pll_go(pll_go),
    .err_lookup(err_lookup), .err_timeout(err_timeout), .warn_div(warn_div));

  // configuration table stimulus
  function automatic void tbl_row(input int i, output logic [31:0] k, d0, d1);
    case (i)
      0: begin k = 32'd1400000; d0 = 32'h0007_0300; d1 = 32'h53; end
      1: begin k = 32'd1000000; d0 = 32'h0005_0230; d1 = 32'h41; end
      2: begin k = 32'd500000;  d0 = 32'h0003_0120; d1 = 32'h35; end
      3: begin k = 32'd300000;  d0 = 32'h0002_0110; d1 = 32'h21; end
      4: begin k = 32'd400000;  d0 = 32'h0002_0100; d1 = 32'h20; end
      default: begin k = 32'd0; d0 = 32'h0; d1 = 32'h0; end
    endcase
  endfunction
  always_comb tbl_row(int'(tbl_idx), tbl_khz, tbl_div0, tbl_div1);

  // mux and divider hardware models
  logic mux_seen = 0; int mux_dly = 0; bit stuck_mux = 0;
  logic [2:0] mstat = 3'd1;
  int b0 = 0, b1 = 0;
  assign mux_stat  = mstat;
  assign div0_busy = div0_we || (b0 != 0);
  assign div1_busy = div1_we || (b1 != 0);
  always @(posedge clk) begin
    if (mux_alt != mux_seen) begin mux_seen <= mux_alt; mux_dly <= 2; mstat <= 3'd4; end
    else if (mux_dly > 0) mux_dly <= mux_dly - 1;
    else if (!stuck_mux) mstat <= mux_seen ? 3'd2 : 3'd1;
    b0 <= div0_we ? 3 : (b0 > 0 ? b0 - 1 : 0);
    b1 <= div1_we ? 3 : (b1 > 0 ? b1 - 1 : 0);
  end

  // monitor
  int n_d0 = 0, n_d1 = 0, n_done = 0;
  logic [31:0] first_d0 = 0, d0_at_mux = 0;
  logic mux_prev = 0;
  always @(posedge clk) begin
    cyc++;
    if (div0_we) begin if (n_d0 == 0) first_d0 = div0_q; n_d0++; end
    if (div1_we) n_d1++;
    if (mux_alt && !mux_prev) d0_at_mux = div0_q;
    mux_prev = mux_alt;
    if (done) n_done++;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    nchk++; nfail++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    summary();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench model state
  logic [31:0] cur0 = 0, cur1 = 0, last_ent0 = 0;
  bit last_osc = 0;
  logic busy_after;

  task automatic clear_log();
    n_d0 = 0; n_d1 = 0; n_done = 0; first_d0 = 0; d0_at_mux = div0_q;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (n_done == 0 && k < 3000) begin @(negedge clk); k++; end
    chk({tag, " done seen"}, 64'(n_done), 64'd1);
  endtask

  task automatic pulse_pre(input logic [31:0] o, n, a);
    @(negedge clk); old_rate = o; new_rate = n; alt_rate = a; pre_req = 1;
    @(negedge clk); pre_req = 0; busy_after = busy;
  endtask

  task automatic pulse_post();
    @(negedge clk); post_req = 1;
    @(negedge clk); post_req = 0; busy_after = busy;
  endtask

  function automatic logic [31:0] exp_altdiv(input logic [31:0] o, n, a);
    logic [63:0] m, q;
    m = (o < n) ? 64'(o) : 64'(n);
    q = (64'(a) + m - 1) / m;
    if (q > 15) q = 15;
    return (q == 0) ? 32'd0 : 32'(q - 1);
  endfunction

  task automatic do_pre(input logic [31:0] o, n, a, input bit exp_tmo);
    bit found = 0, need, osc;
    logic [31:0] t0 = 0, t1 = 0, ad, mask, safe, fin0, fin1, k, d0, d1;
    for (int i = 0; i < 8; i++) begin
      tbl_row(i, k, d0, d1);
      if (k == 0) break;
      if (64'(k) * 1000 == 64'(n)) begin found = 1; t0 = d0; t1 = d1; break; end
    end
    osc = (o == OSC) || (n == OSC);
    clear_log();
    pulse_pre(o, n, a);
    chk("R11 busy after accepted pre", 64'(busy_after), 64'd1);
    wait_done("R11 pre");
    @(negedge clk);
    last_osc = osc;
    if (osc) begin
      chk("R8 no div0 write on osc pre", 64'(n_d0), 64'd0);
      chk("R8 mux unchanged on osc pre", 64'(mux_alt), 64'd0);
      chk("R12 pll_go after osc pre", 64'(pll_go), 64'd1);
    end else if (!found) begin
      chk("R2 err_lookup on miss", 64'(err_lookup), 64'd1);
      chk("R2 no writes on miss", 64'(n_d0 + n_d1), 64'd0);
      chk("R2 mux stays main", 64'(mux_alt), 64'd0);
      chk("R2 pll_go low on miss", 64'(pll_go), 64'd0);
    end else begin
      need = (a > o) || (o > n);
      ad   = exp_altdiv(o, n, a);
      mask = 32'h7 | (cfg_dbg_hold ? 32'h0007_0000 : 32'h0);
      safe = (cur0 & ~mask) | (((ad & 32'h7) | (cfg_dbg_hold ? 32'h0007_0000 : 32'h0)) & mask);
      chk("R3 div0 write count", 64'(n_d0), need ? 64'd2 : 64'd1);
      if (need) begin
        chk("R4 safe divider word", 64'(first_d0), 64'(safe));
        chk("R5 div0 at mux switch is safe word", 64'(d0_at_mux), 64'(safe));
        if (cfg_dbg_hold) chk("R9 debug field held at 7", 64'(first_d0[18:16]), 64'd7);
      end else begin
        chk("R3 div0 untouched at mux switch", 64'(d0_at_mux), 64'(cur0));
      end
      chk("R4 warn_div", 64'(warn_div), 64'(need && ad >= 8));
      fin0 = t0 | (need ? (ad & 32'h7) : 32'h0);
      chk("R5 final div0", 64'(div0_q), 64'(fin0));
      chk("R5 mux on alternate", 64'(mux_alt), 64'd1);
      fin1 = cfg_has_div1 ? (mon_src_alt ? (cur1 & 32'h77) : t1) : cur1;
      chk("R10 div1 value", 64'(div1_q), 64'(fin1));
      chk("R10 div1 write count", 64'(n_d1), 64'(cfg_has_div1));
      chk("R12 pll_go after pre", 64'(pll_go), 64'd1);
      chk("R7 err_timeout", 64'(err_timeout), 64'(exp_tmo));
      cur0 = fin0; cur1 = fin1; last_ent0 = t0;
    end
  endtask

  task automatic do_post();
    logic [31:0] mask, val, e0;
    clear_log();
    pulse_post();
    chk("R11 busy after accepted post", 64'(busy_after), 64'd1);
    wait_done("R11 post");
    @(negedge clk);
    chk("R12 pll_go dropped", 64'(pll_go), 64'd0);
    if (last_osc) begin
      chk("R8 no write on osc post", 64'(n_d0), 64'd0);
    end else begin
      mask = 32'h7 | (cfg_dbg_hold ? 32'h0007_0000 : 32'h0);
      val  = cfg_dbg_hold ? (last_ent0 & 32'h0007_0000) : 32'h0;
      e0   = (cur0 & ~mask) | (val & mask);
      chk("R6 mux back to main", 64'(mux_alt), 64'd0);
      chk("R6 div0 low field cleared", 64'(div0_q), 64'(e0));
      chk("R6 one div0 write", 64'(n_d0), 64'd1);
      if (cfg_dbg_hold) chk("R9 debug field restored", 64'(div0_q[18:16]), 64'(last_ent0[18:16]));
      cur0 = e0;
    end
  endtask

  task automatic expect_ignored(input string tag);
    logic m0;
    m0 = mux_alt;
    repeat (20) @(negedge clk);
    chk({tag, " no done"}, 64'(n_done), 64'd0);
    chk({tag, " not busy"}, 64'(busy_after), 64'd0);
    chk({tag, " mux unchanged"}, 64'(mux_alt), 64'(m0));
    chk({tag, " no writes"}, 64'(n_d0), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 pll_go", 64'(pll_go), 64'd0);
    chk("R1 mux_alt", 64'(mux_alt), 64'd0);
    chk("R1 div words", {div0_q, div1_q}, 64'd0);
    chk("R1 write strobes", 64'({div0_we, div1_we}), 64'd0);
  endtask

  task automatic t_miss();
    do_pre(32'd500_000_000, 32'd123_000_000, 32'd400_000_000, 0);
    clear_log(); pulse_post(); expect_ignored("R11 post without pre");
  endtask

  task automatic t_up_no_safe();
    cfg_has_div1 = 1; mon_src_alt = 0; cfg_dbg_hold = 0;
    do_pre(32'd500_000_000, 32'd1000_000_000, 32'd400_000_000, 0);
    clear_log(); pulse_pre(32'd500_000_000, 32'd500_000_000, 32'd400_000_000);
    expect_ignored("R11 pre while armed");
    do_post();
  endtask

  task automatic t_drop();
    do_pre(32'd1000_000_000, 32'd500_000_000, 32'd800_000_000, 0);
    do_post();
  endtask

  task automatic t_alt_fast();
    do_pre(32'd200_000_000, 32'd300_000_000, 32'd800_000_000, 0);
    do_post();
  endtask

  task automatic t_warn();
    do_pre(32'd200_000_000, 32'd400_000_000, 32'd2000_000_000, 0);
    do_post();
  endtask

  task automatic t_dbg_keep();
    cfg_dbg_hold = 1; mon_src_alt = 1;
    do_pre(32'd1000_000_000, 32'd500_000_000, 32'd1400_000_000, 0);
    do_post();
    cfg_dbg_hold = 0; mon_src_alt = 0;
  endtask

  task automatic t_timeout();
    stuck_mux = 1;
    do_pre(32'd500_000_000, 32'd1000_000_000, 32'd400_000_000, 1);
    stuck_mux = 0;
    repeat (5) @(negedge clk);
    do_post();
  endtask

  task automatic t_osc();
    do_pre(32'd1000_000_000, OSC, 32'd400_000_000, 0);
    do_post();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_miss();
    t_up_no_safe();
    t_drop();
    t_alt_fast();
    t_warn();
    t_dbg_keep();
    t_timeout();
    t_osc();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule